// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the device-side front end of a DRAM emulator. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) with a fast system clock. It then works out what kind of memory cycle the host is running, using only the order in which the strobe edges arrive. It reports each cycle on a set of registered outputs: the latched row and column, a one-cycle write strobe with its data, a one-cycle read strobe, a refresh strobe with the refreshed row, a self-refresh flag and a cycle-kind code.

A small parameterised store stands in for the cell array, so that writes and write suppression show up in the read data. The block applies the output-enable rules that depend on edge order. An early write never drives the outputs. A late write with output enable still low is suppressed and keeps driving read data. The data is held through a hidden refresh. The outputs are released whenever the column strobe is high. Refreshes that use the internal row counter advance that counter by one. Address and write data must be stable from one clock before a strobe edge until four clocks after it. Strobe edges must be at least four clocks apart.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After a synchronous reset, wr_stb, rd_stb, rfsh_stb, self_rfsh and dq_oe are 0 and cyc_kind is 0 (none). The refresh counter is 0 and every store location holds 0.
- R2: A row strobe fall with the column strobe high opens a row at the address pins. A later column strobe fall with write enable high is a read (cyc_kind 1). It pulses rd_stb, latches col_q, and within four clocks drives dout with the stored word at {row low bits, column low bits}. dq_oe is 1 while output enable is low.
- R3: If write enable is low when the column strobe falls, the cycle is an early write (cyc_kind 2). din is written at the column fall, and dq_oe stays 0 for the whole column cycle even with output enable low.
- R4: A write enable fall while the column strobe is low and output enable is high writes din as sampled at that fall. The kind is a late write (3) if output enable stayed high during that column cycle, and a read-modify-write (4) if it had been low.
- R5: A write enable fall while the column strobe is low and output enable is low writes nothing (cyc_kind 5). dout and dq_oe keep showing the read data.
- R6: dq_oe is 0 from at most four clocks after the column strobe goes high for as long as it stays high.
- R7: A row strobe low period with no column strobe fall is a row-only refresh (cyc_kind 6). It pulses rfsh_stb with rfsh_row equal to the opened row.
- R8: A row strobe fall while the column strobe is already low is a counter refresh (cyc_kind 7). It pulses rfsh_stb with rfsh_row equal to the counter, and the counter then advances by one modulo 2^ADDR_W.
- R9: A counter refresh that starts while read data is still held (column strobe never released) is a hidden refresh (cyc_kind 8). dout and dq_oe keep the earlier read data.
- R10: A counter refresh whose row strobe stays low for SELF_CYCLES clocks sets self_rfsh and cyc_kind 9. self_rfsh stays 1 while the row strobe is low and clears after the row strobe goes high.
- R11: Several column strobe cycles within one row strobe low period each access the same latched row at their own column (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data toward the host |
| dq_oe | output | 1 | Data pins driven when 1 |
| row_q | output | ADDR_W | Latched row |
| col_q | output | ADDR_W | Latched column |
| wr_stb | output | 1 | One-cycle write pulse |
| wr_data | output | DATA_W | Data written with wr_stb |
| rd_stb | output | 1 | One-cycle read pulse |
| rfsh_stb | output | 1 | One-cycle refresh pulse |
| rfsh_row | output | ADDR_W | Row refreshed with rfsh_stb |
| self_rfsh | output | 1 | Self-refresh active |
| cyc_kind | output | 4 | Kind of the last classified cycle |

## Verification
A wrong cycle state shows up in cyc_kind and in the strobe counts within four clocks of the edge that was misclassified. A stale early-write or output-enable history shows up as dq_oe being driven, or as an extra or missing write that a later read-back exposes. A refresh counter that skips or stalls shows up as a wrong rfsh_row on the very next counter refresh. A failure to release the outputs is caught on the first clock after the column strobe has been high for four cycles.

// File: rtl/dcd_pkg.sv
// Shared types of the strobe cycle decoder.
// Assumes: cycle-kind codes are visible at the top port and are fixed.
package dcd_pkg;

    typedef enum logic [3:0] {
        K_NONE       = 4'd0,
        K_READ       = 4'd1,
        K_EARLY_WR   = 4'd2,
        K_LATE_WR    = 4'd3,
        K_RMW        = 4'd4,
        K_WR_BLOCKED = 4'd5,
        K_RAS_ONLY   = 4'd6,
        K_CBR        = 4'd7,
        K_HIDDEN     = 4'd8,
        K_SELF       = 4'd9
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CBR,
        ST_SELF
    } dcd_state_t;

endpackage

// File: rtl/dcd_sync.sv
// Two-flop synchroniser per strobe, plus a third flop for edge detection.
// Assumes: strobes are active low, so every stage resets to 1.
// lvl is the synchronised level; chg is 1 for one cycle after lvl changes.
module dcd_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;

        // Capture, settle and delay one strobe bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign lvl[i] = s2;
        assign chg[i] = s2 ^ s3;
    end

endmodule

// File: rtl/dcd_ctrl.sv
// Cycle state machine: classifies each strobe sequence by edge order.
// It latches the row and column, issues write/read/refresh pulses and
// owns the refresh row counter and the self-refresh timer.
// Assumes: strobe bits are {oe, we, cas, ras}, already synchronised.
// Address and data are stable around each strobe edge.
module dcd_ctrl
    import dcd_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 4,
    parameter int SELF_CYCLES = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        lvl,
    input  logic [3:0]        chg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              held,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_q,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb,
    output logic              out_kill,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic              self_rfsh,
    output cyc_kind_t         cyc_kind
);

    localparam int TMR_W = $clog2(SELF_CYCLES + 1);

    dcd_state_t        state;
    logic [ADDR_W-1:0] rcnt;
    logic [TMR_W-1:0]  tmr;
    logic              early, oe_seen, col_seen;

    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_fall;
    logic cas_lvl, we_lvl, oe_lvl;

    // Edge and level decode of the synchronised strobes.
    always_comb begin
        ras_fall = chg[0] & ~lvl[0];
        ras_rise = chg[0] &  lvl[0];
        cas_fall = chg[1] & ~lvl[1];
        cas_rise = chg[1] &  lvl[1];
        we_fall  = chg[2] & ~lvl[2];
        oe_fall  = chg[3] & ~lvl[3];
        cas_lvl  = lvl[1];
        we_lvl   = lvl[2];
        oe_lvl   = lvl[3];
    end

    assign self_rfsh = (state == ST_SELF);

    // Cycle state machine with the registered strobes it issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            row_q    <= '0;
            col_q    <= '0;
            rcnt     <= '0;
            tmr      <= '0;
            early    <= 1'b0;
            oe_seen  <= 1'b0;
            col_seen <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            rd_stb   <= 1'b0;
            out_kill <= 1'b0;
            rfsh_stb <= 1'b0;
            rfsh_row <= '0;
            cyc_kind <= K_NONE;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            out_kill <= 1'b0;
            rfsh_stb <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ras_fall && !cas_lvl) begin
                        state    <= ST_CBR;
                        rfsh_stb <= 1'b1;
                        rfsh_row <= rcnt;
                        rcnt     <= rcnt + 1'b1;
                        tmr      <= '0;
                        cyc_kind <= held ? K_HIDDEN : K_CBR;
                    end else if (ras_fall) begin
                        state    <= ST_ROW;
                        row_q    <= addr;
                        col_seen <= 1'b0;
                    end
                end
                ST_ROW: begin
                    if (ras_rise) begin
                        state <= ST_IDLE;
                        if (!col_seen) begin
                            rfsh_stb <= 1'b1;
                            rfsh_row <= row_q;
                            cyc_kind <= K_RAS_ONLY;
                        end
                    end else if (cas_fall) begin
                        state    <= ST_COL;
                        col_q    <= addr;
                        col_seen <= 1'b1;
                        early    <= ~we_lvl;
                        oe_seen  <= ~oe_lvl;
                        if (!we_lvl) begin
                            wr_stb   <= 1'b1;
                            wr_data  <= din;
                            out_kill <= 1'b1;
                            cyc_kind <= K_EARLY_WR;
                        end else begin
                            rd_stb   <= 1'b1;
                            cyc_kind <= K_READ;
                        end
                    end
                end
                ST_COL: begin
                    if (ras_rise) begin
                        state <= ST_IDLE;
                    end else if (cas_rise) begin
                        state <= ST_ROW;
                    end else if (we_fall && !early) begin
                        if (oe_lvl) begin
                            wr_stb   <= 1'b1;
                            wr_data  <= din;
                            out_kill <= 1'b1;
                            cyc_kind <= oe_seen ? K_RMW : K_LATE_WR;
                        end else begin
                            cyc_kind <= K_WR_BLOCKED;
                        end
                    end else if (oe_fall) begin
                        oe_seen <= 1'b1;
                    end
                end
                ST_CBR: begin
                    if (ras_rise) begin
                        state <= ST_IDLE;
                    end else if (tmr == TMR_W'(SELF_CYCLES - 1)) begin
                        state    <= ST_SELF;
                        cyc_kind <= K_SELF;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_SELF: begin
                    if (ras_rise) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dcd_store.sv
// Stand-in cell array plus the output hold register.
// Assumes: index = {row low bits, column low bits}; reads load the hold
// register, which is released whenever the column strobe is high.
module dcd_store #(
    parameter int DATA_W   = 4,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_hi,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              kill,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write port, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_stb) begin
            mem[idx] <= wr_data;
        end
    end

    // Output hold register: loads on read, drops on release or kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (cas_hi || kill) begin
            out_valid <= 1'b0;
        end else if (rd_stb) begin
            out_data  <= mem[idx];
            out_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dram_cycle_decoder.sv
// Device-side strobe cycle decoder of a DRAM emulator.
// Assumes: strobes are asynchronous and active low; address and data are
// stable from one clock before a strobe edge until four clocks after it.
module dram_cycle_decoder #(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 4,
    parameter int MEM_ROW_BITS = 2,
    parameter int MEM_COL_BITS = 2,
    parameter int SELF_CYCLES  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_q,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic              self_rfsh,
    output logic [3:0]        cyc_kind
);

    localparam int IDX_W = MEM_ROW_BITS + MEM_COL_BITS;

    logic [3:0]          lvl, chg;
    logic                ras_lvl, cas_lvl;
    logic                out_valid, out_kill;
    logic [IDX_W-1:0]    idx;
    dcd_pkg::cyc_kind_t  kind;

    dcd_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({oe_n, we_n, cas_n, ras_n}),
        .lvl   (lvl),
        .chg   (chg)
    );

    assign ras_lvl = lvl[0];
    assign cas_lvl = lvl[1];

    dcd_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SELF_CYCLES (SELF_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .chg       (chg),
        .addr      (addr),
        .din       (din),
        .held      (out_valid),
        .row_q     (row_q),
        .col_q     (col_q),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .out_kill  (out_kill),
        .rfsh_stb  (rfsh_stb),
        .rfsh_row  (rfsh_row),
        .self_rfsh (self_rfsh),
        .cyc_kind  (kind)
    );

    assign idx = {row_q[MEM_ROW_BITS-1:0], col_q[MEM_COL_BITS-1:0]};

    dcd_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cas_hi    (cas_lvl),
        .idx       (idx),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .kill      (out_kill),
        .out_data  (dout),
        .out_valid (out_valid)
    );

    assign cyc_kind = kind;
    assign dq_oe    = out_valid & ~lvl[3] & ~cas_lvl;

endmodule

// File: rtl/dcd_checker.sv
// Temporal checks on the strobe cycle decoder, bound into the top module.
// Assumes: all signals are sampled on the decoder clock after reset.
module dcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_lvl,
    input logic       cas_lvl,
    input logic       out_valid,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       rfsh_stb,
    input logic       self_rfsh,
    input logic [3:0] cyc_kind
);

    a_r6_release_on_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lvl |=> !out_valid);

    a_r3_early_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cyc_kind == 4'd2) |=> !out_valid);

    a_r2_read_loads_output: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !cas_lvl) |=> out_valid);

    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb, rfsh_stb}));

    a_r7_refresh_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_stb |=> !rfsh_stb);

    a_r10_self_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (self_rfsh && !ras_lvl) |=> self_rfsh);

endmodule

bind dram_cycle_decoder dcd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_lvl   (ras_lvl),
    .cas_lvl   (cas_lvl),
    .out_valid (out_valid),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rfsh_stb  (rfsh_stb),
    .self_rfsh (self_rfsh),
    .cyc_kind  (cyc_kind)
);

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;

    localparam int AW   = 12;
    localparam int DW   = 4;
    localparam int SELF = 25000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, wr_data;
    logic          dq_oe, wr_stb, rd_stb, rfsh_stb, self_rfsh;
    logic [AW-1:0] row_q, col_q, rfsh_row;
    logic [3:0]    cyc_kind;

    int checks = 0, errors = 0;
    int n_wr = 0, n_rd = 0, n_rf = 0;
    int last_wr = 0, last_rf = 0;
    int cas_hi_run = 0, cycles = 0;
    int ref_mem [16];
    int ref_cnt = 0;
    int exp_wr = 0, exp_rd = 0, exp_rf = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.ADDR_W(AW), .DATA_W(DW), .SELF_CYCLES(SELF)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
        .row_q(row_q), .col_q(col_q), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row),
        .self_rfsh(self_rfsh), .cyc_kind(cyc_kind)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse monitor and per-clock release check (R6) against the model.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (wr_stb) begin n_wr++; last_wr = int'(wr_data); end
            if (rd_stb) n_rd++;
            if (rfsh_stb) begin n_rf++; last_rf = int'(rfsh_row); end
            cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
            if (cas_hi_run >= 4) chk("R6 release per clock", int'(dq_oe), 0);
        end
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input logic r, input logic c, input logic w, input logic o,
                        input int a, input int d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        addr = AW'(a); din = DW'(d);
        repeat (4) @(negedge clk);
    endtask

    function automatic int ix(input int r, input int c);
        return (r % 4) * 4 + (c % 4);
    endfunction

    // Read at (r,c) with oe low; leaves strobes low.
    task automatic do_read(input string req, input int r, input int c);
        step(1, 1, 1, 0, r, 0);
        step(0, 1, 1, 0, r, 0);
        step(0, 0, 1, 0, c, 0);
        exp_rd++;
        chk({req, " rd count"}, n_rd, exp_rd);
        chk({req, " kind read"}, int'(cyc_kind), 1);
        chk({req, " dq_oe"}, int'(dq_oe), 1);
        chk({req, " dout"}, int'(dout), ref_mem[ix(r, c)]);
    endtask

    task automatic close_all();
        step(1, 1, 1, 1, 0, 0);
    endtask

    initial begin
        foreach (ref_mem[i]) ref_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_stb", int'(wr_stb), 0);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 kind", int'(cyc_kind), 0);
        chk("R1 self", int'(self_rfsh), 0);

        // R3 early write row 1 col 2 data 10 with oe low
        step(0, 1, 1, 1, 1, 0);
        step(0, 1, 0, 0, 2, 10);
        step(0, 0, 0, 0, 2, 10);
        exp_wr++; ref_mem[ix(1, 2)] = 10;
        chk("R3 wr count", n_wr, exp_wr);
        chk("R3 wr data", last_wr, 10);
        chk("R3 kind", int'(cyc_kind), 2);
        chk("R3 row", int'(row_q), 1);
        chk("R3 col", int'(col_q), 2);
        chk("R3 no drive", int'(dq_oe), 0);
        close_all();

        // R2 read back, R11 page mode second column, R6 release
        do_read("R2", 1, 2);
        step(0, 1, 1, 0, 3, 0);
        chk("R6 released", int'(dq_oe), 0);
        step(0, 0, 1, 0, 3, 0);
        exp_rd++;
        chk("R11 rd count", n_rd, exp_rd);
        chk("R11 row kept", int'(row_q), 1);
        chk("R11 col", int'(col_q), 3);
        chk("R11 dout", int'(dout), ref_mem[ix(1, 3)]);
        close_all();

        // R4 late write with oe high throughout
        step(1, 1, 1, 1, 2, 0);
        step(0, 1, 1, 1, 2, 0);
        step(0, 0, 1, 1, 1, 0);
        exp_rd++;
        step(0, 0, 0, 1, 1, 5);
        exp_wr++; ref_mem[ix(2, 1)] = 5;
        chk("R4 late wr count", n_wr, exp_wr);
        chk("R4 late kind", int'(cyc_kind), 3);
        chk("R4 late data", last_wr, 5);
        close_all();

        // R4 read-modify-write: read with oe low, raise oe, then we falls
        do_read("R4 rmw read", 2, 1);
        step(0, 0, 1, 1, 1, 9);
        step(0, 0, 0, 1, 1, 9);
        exp_wr++; ref_mem[ix(2, 1)] = 9;
        chk("R4 rmw wr count", n_wr, exp_wr);
        chk("R4 rmw kind", int'(cyc_kind), 4);
        close_all();

        // R5 write with oe low is suppressed
        do_read("R5 read", 2, 1);
        step(0, 0, 0, 0, 1, 3);
        chk("R5 no write", n_wr, exp_wr);
        chk("R5 kind", int'(cyc_kind), 5);
        chk("R5 still driving", int'(dq_oe), 1);
        chk("R5 dout", int'(dout), 9);
        close_all();
        do_read("R5 readback", 2, 1);
        close_all();

        // R7 row-only refresh of row 7
        step(0, 1, 1, 1, 7, 0);
        step(1, 1, 1, 1, 7, 0);
        exp_rf++;
        chk("R7 rf count", n_rf, exp_rf);
        chk("R7 row", last_rf, 7);
        chk("R7 kind", int'(cyc_kind), 6);

        // R8 two counter refreshes
        for (int k = 0; k < 2; k++) begin
            step(1, 0, 1, 1, 0, 0);
            step(0, 0, 1, 1, 0, 0);
            exp_rf++;
            chk("R8 rf count", n_rf, exp_rf);
            chk("R8 counter row", last_rf, ref_cnt);
            chk("R8 kind", int'(cyc_kind), 7);
            ref_cnt++;
            close_all();
        end

        // R9 hidden refresh after a read keeps the data
        do_read("R9 read", 1, 2);
        step(1, 0, 1, 0, 0, 0);
        chk("R9 held during ras high", int'(dout), 10);
        step(0, 0, 1, 0, 0, 0);
        exp_rf++;
        chk("R9 kind", int'(cyc_kind), 8);
        chk("R9 counter row", last_rf, ref_cnt);
        chk("R9 dq_oe", int'(dq_oe), 1);
        chk("R9 dout", int'(dout), 10);
        ref_cnt++;
        close_all();

        // R10 self refresh
        step(1, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        exp_rf++;
        chk("R10 entry refresh row", last_rf, ref_cnt);
        repeat (SELF - 20) @(negedge clk);
        chk("R10 not yet", int'(self_rfsh), 0);
        repeat (40) @(negedge clk);
        chk("R10 self set", int'(self_rfsh), 1);
        chk("R10 kind", int'(cyc_kind), 9);
        close_all();
        chk("R10 self cleared", int'(self_rfsh), 0);
        chk("R8 total refreshes", n_rf, exp_rf);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule